// File: doc/BRIEF.md
# Instruction Header and Dispatch Sequencer

This block starts the processing of every instruction. When `start` is pulsed it takes the program counter and a code-base value and forms the byte fetch address from them. It checks that a complete instruction of maximum length fits below the top of memory, then reads the first instruction byte through a synchronous byte memory port. If the top bit of that byte is set, the block reads a second attribute byte. The attribute byte carries a repeat flag, a bus-lock flag and a condition field.

After the header bytes, the block checks the opcode range and reads the opcode's operand count from a table supplied on an input port. It then hands control to an external operand decoder up to three times, one operand after another. For each operand it passes the current program counter and collects the decoded value and the number of bytes that operand consumed. At the end it produces either a one-cycle dispatch strobe, with the opcode, the attributes and the collected operands, or a one-cycle fault strobe with a fault code. A fault ends the sequence at once.

Top module: `instr_header_seq`

## Requirements
- R1: The fetch address is `pcIn + codeBase - MEM_OFFSET`, taken modulo 2^AW. The first memory read of an instruction goes to that address, and an attribute byte, if present, is read from the next address.
- R2: If the fetch address is greater than or equal to `MEM_SIZE - MAX_INSTR_LEN`, the block raises a fault with code 1 (access). No memory read and no operand request happens for that instruction.
- R3: When bit 7 of the first byte is 1, the opcode is bits 6:0 of that byte and a second byte is read. When bit 7 is 0, only one byte is read and all attribute outputs are 0.
- R4: An opcode greater than or equal to `NUM_INSTR` raises a fault with code 2 (illegal), with no dispatch and no operand request. With an attribute byte present, this check is made after the attribute byte has been read.
- R5: In the attribute byte, bit 0 is the repeat flag, bit 1 is the lock flag and bits 6:2 are the condition field. Bit 7 is ignored.
- R6: The operand count for opcode i is `opCountTable[2*i+1:2*i]` (0 to 3). Exactly that many operand requests are issued, and every operand slot beyond the count reads 0 at dispatch. Slot k is `dispOperands[k*OPW +: OPW]`.
- R7: Each operand request presents on `opPc` the program counter just after the header bytes, plus the `opLen` values of all earlier operands of the same instruction.
- R8: At dispatch, `curPc` equals the `pcIn` of the instruction and `nextPc` equals `pcIn` plus every byte consumed (the header bytes plus all operand lengths).
- R9: An operand decoder response with `opFault` set raises a fault with code 3 (operand). No further operand request and no dispatch follow.
- R10: Each accepted `start` ends in exactly one one-cycle strobe, either `dispValid` or `faultValid`, never both. `busy` is high from the cycle after `start` until that strobe, and low while the strobe is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken while idle) |
| pcIn | input | AW | Program counter of the instruction |
| codeBase | input | AW | Code-base value added to the program counter |
| busy | output | 1 | Sequence in progress |
| memRdEn | output | 1 | Byte read request |
| memAddr | output | AW | Byte read address |
| memRdData | input | 8 | Read data, valid one cycle after the request |
| opCountTable | input | 2*NUM_INSTR | Packed operand count per opcode |
| opReq | output | 1 | Operand decode request, one cycle |
| opPc | output | AW | Program counter where the operand starts |
| opDone | input | 1 | Operand decoder response strobe |
| opLen | input | LEN_W | Bytes consumed by the operand |
| opData | input | OPW | Decoded operand value |
| opFault | input | 1 | Operand decode failed |
| dispValid | output | 1 | Dispatch strobe |
| dispOpcode | output | 7 | Opcode |
| dispRep | output | 1 | Repeat attribute |
| dispLock | output | 1 | Lock attribute |
| dispCond | output | 5 | Condition attribute |
| dispNumOps | output | 2 | Operand count |
| dispOperands | output | 3*OPW | Collected operands, slot 0 lowest |
| curPc | output | AW | Address of the instruction start |
| nextPc | output | AW | Program counter after consumed bytes |
| faultValid | output | 1 | Fault strobe |
| faultCode | output | 2 | 1 access, 2 illegal, 3 operand |

## Verification
The assertions assume the following about the inputs:
- The byte memory returns data exactly one cycle after a request.
- The operand decoder raises `opDone` only while a request it accepted is still outstanding, and reports a nonzero `opLen`.
- `start` arrives only while `busy` is low.

The bench models the memory and the decoder so that they follow these rules: the decoder answers one to three cycles after each request, with lengths of 1 to 5, and `start` is driven only after the previous strobe has ended. The read-range assertion relies on the fetch address check. Without that check, a header read could reach beyond the allowed window.

// File: rtl/hdr_seq_pkg.sv
package hdr_seq_pkg;

  localparam int OPC_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int COND_W  = 5;
  localparam int CNT_W   = 2;
  localparam int MAX_OPS = 3;

  localparam logic [1:0] FAULT_ACCESS  = 2'd1;
  localparam logic [1:0] FAULT_ILLEGAL = 2'd2;
  localparam logic [1:0] FAULT_OPERAND = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR_WAIT,
    ST_SFX_WAIT,
    ST_LOOKUP,
    ST_OP_ISSUE,
    ST_OP_WAIT
  } seqState_e;

  typedef struct packed {
    logic latchStart;
    logic stepPc;
    logic capFirst;
    logic capSuffix;
    logic capCount;
    logic capOperand;
  } seqStrobes_t;

endpackage

// File: rtl/hdr_datapath.sv
module hdr_datapath
  import hdr_seq_pkg::*;
#(
  parameter int          AW            = 32,
  parameter int          OPW           = 64,
  parameter int          LEN_W         = 4,
  parameter int          NUM_INSTR     = 64,
  parameter int unsigned MEM_SIZE      = 65536,
  parameter int unsigned MEM_OFFSET    = 4096,
  parameter int unsigned MAX_INSTR_LEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  seqStrobes_t              strobes,
  input  logic [AW-1:0]            pcIn,
  input  logic [AW-1:0]            codeBase,
  input  logic [BYTE_W-1:0]        memRdData,
  input  logic [2*NUM_INSTR-1:0]   opCountTable,
  input  logic [LEN_W-1:0]         opLen,
  input  logic [OPW-1:0]           opData,
  output logic [AW-1:0]            fetchAddr,
  output logic                     fetchBad,
  output logic                     opcodeBad,
  output logic                     opsDone,
  output logic [OPC_W-1:0]         opcodeOut,
  output logic [BYTE_W-1:0]        suffixOut,
  output logic [CNT_W-1:0]         countOut,
  output logic [MAX_OPS*OPW-1:0]   operandsOut,
  output logic [AW-1:0]            pcOut,
  output logic [AW-1:0]            curPcOut
);

  localparam logic [AW-1:0] FETCH_LIMIT = AW'(MEM_SIZE - MAX_INSTR_LEN);
  localparam logic [AW-1:0] OFFSET_V    = AW'(MEM_OFFSET);

  logic [AW-1:0]     pcReg;
  logic [AW-1:0]     curPcReg;
  logic [AW-1:0]     baseReg;
  logic [OPC_W-1:0]  opcodeReg;
  logic [BYTE_W-1:0] suffixReg;
  logic [CNT_W-1:0]  countReg;
  logic [CNT_W-1:0]  idxReg;
  logic [CNT_W-1:0]  countLookup;
  logic [OPW-1:0]    operandReg [MAX_OPS];

  assign fetchAddr = pcReg + baseReg - OFFSET_V;
  assign fetchBad  = (fetchAddr >= FETCH_LIMIT);
  assign opcodeBad = (int'(opcodeReg) >= NUM_INSTR);
  assign opsDone   = (idxReg == countReg);

  always_comb begin
    countLookup = '0;
    for (int i = 0; i < NUM_INSTR; i++) begin
      if (opcodeReg == OPC_W'(i)) countLookup = opCountTable[2*i +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcReg     <= '0;
      curPcReg  <= '0;
      baseReg   <= '0;
      opcodeReg <= '0;
      suffixReg <= '0;
      countReg  <= '0;
      idxReg    <= '0;
    end else begin
      if (strobes.latchStart) begin
        pcReg    <= pcIn;
        curPcReg <= pcIn;
        baseReg  <= codeBase;
        countReg <= '0;
        idxReg   <= '0;
      end else if (strobes.stepPc) begin
        pcReg <= pcReg + AW'(1);
      end else if (strobes.capOperand) begin
        pcReg  <= pcReg + AW'(opLen);
        idxReg <= idxReg + CNT_W'(1);
      end
      if (strobes.capFirst) begin
        opcodeReg <= memRdData[OPC_W-1:0];
        suffixReg <= '0;
      end
      if (strobes.capSuffix) suffixReg <= memRdData;
      if (strobes.capCount) begin
        countReg <= countLookup;
        idxReg   <= '0;
      end
    end
  end

  for (genvar k = 0; k < MAX_OPS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || strobes.latchStart) begin
        operandReg[k] <= '0;
      end else if (strobes.capOperand && idxReg == CNT_W'(k)) begin
        operandReg[k] <= opData;
      end
    end
    assign operandsOut[k*OPW +: OPW] = operandReg[k];
  end

  assign opcodeOut = opcodeReg;
  assign suffixOut = suffixReg;
  assign countOut  = countReg;
  assign pcOut     = pcReg;
  assign curPcOut  = curPcReg;

endmodule

// File: rtl/hdr_control.sv
module hdr_control
  import hdr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        fetchBad,
  input  logic        hasSuffix,
  input  logic        opcodeBad,
  input  logic        opsDone,
  input  logic        opDone,
  input  logic        opFault,
  output seqStrobes_t strobes,
  output logic        memRdEn,
  output logic        opReq,
  output logic        busy,
  output logic        dispValid,
  output logic        faultValid,
  output logic [1:0]  faultCode
);

  seqState_e stateReg, stateNext;
  logic       raiseFault;
  logic       raiseDisp;
  logic [1:0] faultKind;

  always_comb begin
    stateNext  = stateReg;
    strobes    = '0;
    memRdEn    = 1'b0;
    opReq      = 1'b0;
    raiseFault = 1'b0;
    raiseDisp  = 1'b0;
    faultKind  = FAULT_ACCESS;
    unique case (stateReg)
      ST_IDLE: begin
        if (start) begin
          strobes.latchStart = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (fetchBad) begin
          raiseFault = 1'b1;
          faultKind  = FAULT_ACCESS;
          stateNext  = ST_IDLE;
        end else begin
          memRdEn        = 1'b1;
          strobes.stepPc = 1'b1;
          stateNext      = ST_HDR_WAIT;
        end
      end
      ST_HDR_WAIT: begin
        strobes.capFirst = 1'b1;
        if (hasSuffix) begin
          memRdEn        = 1'b1;
          strobes.stepPc = 1'b1;
          stateNext      = ST_SFX_WAIT;
        end else begin
          stateNext = ST_LOOKUP;
        end
      end
      ST_SFX_WAIT: begin
        strobes.capSuffix = 1'b1;
        stateNext = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (opcodeBad) begin
          raiseFault = 1'b1;
          faultKind  = FAULT_ILLEGAL;
          stateNext  = ST_IDLE;
        end else begin
          strobes.capCount = 1'b1;
          stateNext = ST_OP_ISSUE;
        end
      end
      ST_OP_ISSUE: begin
        if (opsDone) begin
          raiseDisp = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          opReq     = 1'b1;
          stateNext = ST_OP_WAIT;
        end
      end
      ST_OP_WAIT: begin
        if (opDone) begin
          if (opFault) begin
            raiseFault = 1'b1;
            faultKind  = FAULT_OPERAND;
            stateNext  = ST_IDLE;
          end else begin
            strobes.capOperand = 1'b1;
            stateNext = ST_OP_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateReg   <= ST_IDLE;
      dispValid  <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= '0;
    end else begin
      stateReg   <= stateNext;
      dispValid  <= raiseDisp;
      faultValid <= raiseFault;
      if (raiseFault) faultCode <= faultKind;
    end
  end

  assign busy = (stateReg != ST_IDLE);

endmodule

// File: rtl/instr_header_seq.sv
module instr_header_seq
  import hdr_seq_pkg::*;
#(
  parameter int          AW            = 32,
  parameter int          OPW           = 64,
  parameter int          LEN_W         = 4,
  parameter int          NUM_INSTR     = 64,
  parameter int unsigned MEM_SIZE      = 65536,
  parameter int unsigned MEM_OFFSET    = 4096,
  parameter int unsigned MAX_INSTR_LEN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          pcIn,
  input  logic [AW-1:0]          codeBase,
  output logic                   busy,
  output logic                   memRdEn,
  output logic [AW-1:0]          memAddr,
  input  logic [7:0]             memRdData,
  input  logic [2*NUM_INSTR-1:0] opCountTable,
  output logic                   opReq,
  output logic [AW-1:0]          opPc,
  input  logic                   opDone,
  input  logic [LEN_W-1:0]       opLen,
  input  logic [OPW-1:0]         opData,
  input  logic                   opFault,
  output logic                   dispValid,
  output logic [6:0]             dispOpcode,
  output logic                   dispRep,
  output logic                   dispLock,
  output logic [4:0]             dispCond,
  output logic [1:0]             dispNumOps,
  output logic [3*OPW-1:0]       dispOperands,
  output logic [AW-1:0]          curPc,
  output logic [AW-1:0]          nextPc,
  output logic                   faultValid,
  output logic [1:0]             faultCode
);

  seqStrobes_t       strobes;
  logic              fetchBad;
  logic              opcodeBad;
  logic              opsDone;
  logic [BYTE_W-1:0] suffix;

  hdr_control ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fetchBad   (fetchBad),
    .hasSuffix  (memRdData[7]),
    .opcodeBad  (opcodeBad),
    .opsDone    (opsDone),
    .opDone     (opDone),
    .opFault    (opFault),
    .strobes    (strobes),
    .memRdEn    (memRdEn),
    .opReq      (opReq),
    .busy       (busy),
    .dispValid  (dispValid),
    .faultValid (faultValid),
    .faultCode  (faultCode)
  );

  hdr_datapath #(
    .AW            (AW),
    .OPW           (OPW),
    .LEN_W         (LEN_W),
    .NUM_INSTR     (NUM_INSTR),
    .MEM_SIZE      (MEM_SIZE),
    .MEM_OFFSET    (MEM_OFFSET),
    .MAX_INSTR_LEN (MAX_INSTR_LEN)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .pcIn         (pcIn),
    .codeBase     (codeBase),
    .memRdData    (memRdData),
    .opCountTable (opCountTable),
    .opLen        (opLen),
    .opData       (opData),
    .fetchAddr    (memAddr),
    .fetchBad     (fetchBad),
    .opcodeBad    (opcodeBad),
    .opsDone      (opsDone),
    .opcodeOut    (dispOpcode),
    .suffixOut    (suffix),
    .countOut     (dispNumOps),
    .operandsOut  (dispOperands),
    .pcOut        (nextPc),
    .curPcOut     (curPc)
  );

  assign opPc     = nextPc;
  assign dispRep  = suffix[0];
  assign dispLock = suffix[1];
  assign dispCond = suffix[6:2];

endmodule

// File: rtl/hdr_seq_checker.sv
module hdr_seq_checker #(
  parameter int          AW            = 32,
  parameter int          NUM_INSTR     = 64,
  parameter int unsigned MEM_SIZE      = 65536,
  parameter int unsigned MAX_INSTR_LEN = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          memRdEn,
  input logic [AW-1:0] memAddr,
  input logic          opReq,
  input logic          dispValid,
  input logic [6:0]    dispOpcode,
  input logic          faultValid,
  input logic [1:0]    faultCode
);

  localparam logic [AW-1:0] READ_CEIL = AW'(MEM_SIZE - MAX_INSTR_LEN + 1);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dispValid && faultValid));

  // R10
  disp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |=> !dispValid);

  // R10
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |=> !faultValid);

  // R10
  idle_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dispValid || faultValid) |-> !busy);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> (memAddr < READ_CEIL));

  // R4
  legal_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> (int'(dispOpcode) < NUM_INSTR));

  // R6
  op_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opReq |=> !opReq);

  // R9
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |-> (faultCode != 2'd0));

endmodule

bind instr_header_seq hdr_seq_checker #(
  .AW            (AW),
  .NUM_INSTR     (NUM_INSTR),
  .MEM_SIZE      (MEM_SIZE),
  .MAX_INSTR_LEN (MAX_INSTR_LEN)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .memRdEn    (memRdEn),
  .memAddr    (memAddr),
  .opReq      (opReq),
  .dispValid  (dispValid),
  .dispOpcode (dispOpcode),
  .faultValid (faultValid),
  .faultCode  (faultCode)
);

// File: tb/instr_header_seq_tb_top.sv
module instr_header_seq_tb_top;

  localparam int AW    = 16;
  localparam int OPW   = 16;
  localparam int LEN_W = 4;
  localparam int NI    = 64;
  localparam int MSIZE = 256;
  localparam int MOFF  = 256;
  localparam int MAXL  = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [AW-1:0]       pcIn = '0;
  logic [AW-1:0]       codeBase = '0;
  logic                busy;
  logic                memRdEn;
  logic [AW-1:0]       memAddr;
  logic [7:0]          memRdData = '0;
  logic [2*NI-1:0]     opCountTable;
  logic                opReq;
  logic [AW-1:0]       opPc;
  logic                opDone = 1'b0;
  logic [LEN_W-1:0]    opLen = '0;
  logic [OPW-1:0]      opData = '0;
  logic                opFault = 1'b0;
  logic                dispValid;
  logic [6:0]          dispOpcode;
  logic                dispRep;
  logic                dispLock;
  logic [4:0]          dispCond;
  logic [1:0]          dispNumOps;
  logic [3*OPW-1:0]    dispOperands;
  logic [AW-1:0]       curPc;
  logic [AW-1:0]       nextPc;
  logic                faultValid;
  logic [1:0]          faultCode;

  always #4 clk = ~clk;

  instr_header_seq #(
    .AW(AW), .OPW(OPW), .LEN_W(LEN_W), .NUM_INSTR(NI),
    .MEM_SIZE(MSIZE), .MEM_OFFSET(MOFF), .MAX_INSTR_LEN(MAXL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pcIn(pcIn), .codeBase(codeBase),
    .busy(busy), .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .opCountTable(opCountTable), .opReq(opReq), .opPc(opPc), .opDone(opDone),
    .opLen(opLen), .opData(opData), .opFault(opFault), .dispValid(dispValid),
    .dispOpcode(dispOpcode), .dispRep(dispRep), .dispLock(dispLock),
    .dispCond(dispCond), .dispNumOps(dispNumOps), .dispOperands(dispOperands),
    .curPc(curPc), .nextPc(nextPc), .faultValid(faultValid), .faultCode(faultCode)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] mem [MSIZE];
  int readLog [4];
  int readCnt = 0;
  int reqLog  [4];
  int reqCnt  = 0;
  int faultAt = -1;
  int waitCnt = 0;
  int pendPc  = 0;

  function automatic int lenOf(int p);
    return (p % 5) + 1;
  endfunction

  function automatic int dataOf(int p);
    return ((p * 3) ^ 16'h5A5A) & 16'hFFFF;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial for (int i = 0; i < NI; i++) opCountTable[2*i +: 2] = 2'(i % 4);

  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr[7:0]];

  // bus monitor and operand decoder model, sampled mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (memRdEn && readCnt < 4) begin
        readLog[readCnt] = int'(memAddr);
        readCnt++;
      end
      opDone = 1'b0;
      if (waitCnt > 0) begin
        waitCnt--;
        if (waitCnt == 0) begin
          opDone  = 1'b1;
          opLen   = LEN_W'(lenOf(pendPc));
          opData  = OPW'(dataOf(pendPc));
          opFault = (pendPc == faultAt);
        end
      end else if (opReq) begin
        if (reqCnt < 4) reqLog[reqCnt] = int'(opPc);
        reqCnt++;
        pendPc  = int'(opPc);
        waitCnt = 1 + (pendPc % 3);
      end
    end
  end

  task automatic runCase(int pc, int base, int b1, int sfx, int fltAt);
    int fa, hdrLen, opc, n, p, expCode, expReqs, expReads;
    int expData [3];
    int cyc;
    bit gotDisp, gotFault;
    fa = (pc + base - MOFF) & 16'hFFFF;
    if (fa < MSIZE) mem[fa] = 8'(b1);
    if (fa + 1 < MSIZE) mem[fa + 1] = 8'(sfx);
    hdrLen = ((b1 & 8'h80) != 0) ? 2 : 1;
    opc = b1 & 8'h7F;
    expCode = 0; expReqs = 0; expReads = 0; n = 0; p = pc + hdrLen;
    for (int k = 0; k < 3; k++) expData[k] = 0;
    if (fa >= MSIZE - MAXL) begin
      expCode = 1;
    end else begin
      expReads = hdrLen;
      if (opc >= NI) expCode = 2;
      else begin
        n = opc % 4;
        for (int k = 0; k < n; k++) begin
          if (expCode == 0) begin
            expReqs++;
            if ((p & 16'hFFFF) == fltAt) expCode = 3;
            else begin
              expData[k] = dataOf(p & 16'hFFFF);
              p = p + lenOf(p & 16'hFFFF);
            end
          end
        end
      end
    end
    faultAt = fltAt;
    readCnt = 0; reqCnt = 0;
    @(negedge clk);
    pcIn = AW'(pc); codeBase = AW'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotDisp = 0; gotFault = 0;
    for (cyc = 0; cyc < 200 && !gotDisp && !gotFault; cyc++) begin
      if (dispValid) gotDisp = 1;
      else if (faultValid) gotFault = 1;
      else @(negedge clk);
    end
    if (expCode != 0) begin
      check(gotFault && !dispValid, "R10", "fault strobe alone", {gotFault, dispValid}, 2'b10);
      check(faultCode == 2'(expCode), expCode == 1 ? "R2" : (expCode == 2 ? "R4" : "R9"),
            "fault code", faultCode, expCode);
    end else begin
      check(gotDisp && !faultValid, "R10", "dispatch strobe alone", {gotDisp, faultValid}, 2'b10);
      check(dispOpcode == 7'(opc), "R3", "opcode", dispOpcode, opc);
      check({dispCond, dispLock, dispRep} == (hdrLen == 2 ? 7'(sfx) : 7'd0), "R5",
            "attributes", {dispCond, dispLock, dispRep}, hdrLen == 2 ? (sfx & 8'h7F) : 0);
      check(dispNumOps == 2'(n), "R6", "operand count", dispNumOps, n);
      for (int k = 0; k < 3; k++)
        check(dispOperands[k*OPW +: OPW] == OPW'(expData[k]), "R6", "operand slot",
              dispOperands[k*OPW +: OPW], expData[k]);
      check(curPc == AW'(pc), "R8", "curPc", curPc, pc);
      check(nextPc == AW'(p), "R8", "nextPc", nextPc, p & 16'hFFFF);
    end
    check(!busy, "R10", "busy at strobe", busy, 0);
    check(reqCnt == expReqs, "R6", "operand requests", reqCnt, expReqs);
    check(readCnt == expReads, "R1", "header reads", readCnt, expReads);
    if (expReads > 0) check(readLog[0] == fa, "R1", "first read addr", readLog[0], fa);
    if (expReads > 1) check(readLog[1] == fa + 1, "R3", "suffix read addr", readLog[1], fa + 1);
    p = pc + hdrLen;
    for (int k = 0; k < expReqs && k < 4; k++) begin
      check(reqLog[k] == (p & 16'hFFFF), "R7", "operand pc", reqLog[k], p & 16'hFFFF);
      p = p + lenOf(p & 16'hFFFF);
    end
    @(negedge clk);
    check(!dispValid && !faultValid, "R10", "strobe one cycle", {dispValid, faultValid}, 0);
  endtask

  bit finished = 0;

  initial begin
    for (int i = 0; i < MSIZE; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !dispValid && !faultValid && !memRdEn && !opReq, "R10", "reset state",
          {busy, dispValid, faultValid, memRdEn, opReq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep every first-byte value with varied attribute bytes and placements
    for (int b = 0; b < 256; b++)
      runCase(MOFF + (b % 150), b % 7, b, (b * 37 + 11) & 8'hFF, -1);
    // fetch window boundaries
    runCase(MOFF + 223, 0, 8'h83, 8'hFF, -1);
    runCase(MOFF + 220, 3, 8'h03, 8'h00, -1);
    runCase(MOFF + 224, 0, 8'h01, 8'h00, -1);
    runCase(MOFF + 200, 55, 8'h02, 8'h00, -1);
    runCase(MOFF - 16, 0, 8'h01, 8'h00, -1);
    // opcode range edges
    runCase(MOFF + 10, 0, 8'h3F, 8'h00, -1);
    runCase(MOFF + 10, 0, 8'h40, 8'h00, -1);
    runCase(MOFF + 10, 0, 8'hC0, 8'h55, -1);
    runCase(MOFF + 10, 0, 8'hBF, 8'hAA, -1);
    // operand decoder faults on first, second and third operand
    runCase(MOFF + 20, 0, 8'h03, 8'h00, MOFF + 21);
    runCase(MOFF + 20, 0, 8'h83, 8'h07, MOFF + 22 + lenOf(MOFF + 22));
    runCase(MOFF + 40, 1, 8'h07, 8'h00,
            MOFF + 41 + lenOf(MOFF + 41) + lenOf(MOFF + 41 + lenOf(MOFF + 41)));
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule